// File: doc/BRIEF.md
# USB Controller Command and Status Register Unit

This block sits between a simple single-cycle CPU register bus and a USB controller core. It holds the software-visible command word (a run/stop control and a self-clearing controller-reset control), the status word (a halted flag plus sticky event flags that software clears by writing ones), and an interrupt-enable word. Toward the core it drives a reset request, a gated run enable, the device-mode attach pull-up enable and one combined interrupt line. The core supplies a transaction-busy level, a reset-complete strobe, per-event pulses and a high-speed-entered indication.

A controller reset, once started, runs until the core reports completion, and software cannot cut it short. When software clears run/stop, the halted flag is not raised until the transaction in flight has finished. The pull-up follows run/stop, but it is dropped as soon as the link enters high speed and stays off until run/stop is cleared.

Top module: `usb_cmdstat_regs`

## Requirements
- R1: After reset the command word (address 0) reads 0, the status word (address 1) reads 0x0000_1000 (only halted set), the enable word (address 2) reads 0, and `irq`, `pullup_en`, `core_run` and `core_reset_req` are 0.
- R2: Writing the command word with bit 1 set raises `core_reset_req`, and command bit 1 reads 1, from the next cycle. Both stay set until the cycle after `core_reset_done` is seen, then both read 0.
- R3: While a controller reset is pending, writing 0 to command bit 1 leaves the reset pending.
- R4: While a reset is pending, `core_run` and `pullup_en` are 0. When the reset completes, command bit 0 (run) is cleared and status bit 12 (halted) is set.
- R5: Writing command bit 0 = 1 sets run, raises `core_run` and clears halted, all in the same cycle. Halted reads 0 for as long as run stays 1.
- R6: After run is cleared, halted (status bit 12) becomes 1 at the first clock edge at which `core_xfer_busy` is low. It stays 0 while the core reports a transaction in progress.
- R7: `pullup_en` is 1 when run is 1, no reset is pending and no high-speed entry has been seen since run was last set. It goes to 0 in the same cycle that `core_hs_entered` is asserted.
- R8: A pulse on `core_evt[i]` sets status bit i at that clock edge. The bits, from bit 0 upward, are: USB interrupt, USB error, port change, frame rollover, system error, async advance, bus reset received, start-of-frame received, suspend, and PHY-bus event.
- R9: Writing the status word clears each event bit that is written with a 1 and leaves bits written with 0 unchanged. Halted cannot be written. If a clear and a new event hit the same bit in the same cycle, the bit ends up set.
- R10: `irq` is 1 exactly when some status event bit and the matching enable bit (address 2, bits 9..0) are both 1.
- R11: Unused addresses and unused bit positions read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| core_xfer_busy | input | 1 | Core has a transaction in progress |
| core_reset_done | input | 1 | Core finished its internal reset |
| core_evt | input | NUM_EVT | Event pulses, one per status bit |
| core_hs_entered | input | 1 | Link has entered high speed |
| core_reset_req | output | 1 | Request to reset the core |
| core_run | output | 1 | Run enable to the core |
| pullup_en | output | 1 | Device-mode attach pull-up enable |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes take effect at the clock edge that captures them. The command, status and enable words, `core_run`, `core_reset_req` and `irq` therefore change one edge after the write strobe, and reads are combinational in the same cycle. Halted rises at the first edge at which run is 0 and the core is idle. `pullup_en` drops combinationally in the cycle that high speed is signalled. The bench drives every input on the falling edge, then either advances exactly one rising edge before sampling at the next falling edge, or, for the combinational paths, samples a short delay after driving.

// File: rtl/usb_cmdstat_regs.sv
module usb_cmdstat_regs #(
  parameter int ADDR_W   = 4,
  parameter int NUM_EVT  = 10,
  parameter int HALT_POS = 12,
  parameter int CMD_ADDR = 0,
  parameter int STS_ADDR = 1,
  parameter int IEN_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              core_xfer_busy,
  input  logic              core_reset_done,
  input  logic [NUM_EVT-1:0] core_evt,
  input  logic              core_hs_entered,
  output logic              core_reset_req,
  output logic              core_run,
  output logic              pullup_en,
  output logic              irq
);
  localparam int RUN_POS = 0;
  localparam int RST_POS = 1;
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(CMD_ADDR);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(STS_ADDR);
  localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(IEN_ADDR);

  logic run_q, rst_busy, halted_q, hs_seen;
  logic [NUM_EVT-1:0] evt_q, ien_q, clr_mask;
  logic wr_cmd, wr_sts, wr_ien, rst_fin;

  assign wr_cmd  = bus_we && (bus_addr == A_CMD);
  assign wr_sts  = bus_we && (bus_addr == A_STS);
  assign wr_ien  = bus_we && (bus_addr == A_IEN);
  assign rst_fin = rst_busy && core_reset_done;
  assign clr_mask = wr_sts ? bus_wdata[NUM_EVT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      rst_busy <= 1'b0;
      halted_q <= 1'b1;
      hs_seen  <= 1'b0;
      evt_q    <= '0;
      ien_q    <= '0;
    end else begin
      if (rst_fin)
        rst_busy <= 1'b0;
      else if (wr_cmd && bus_wdata[RST_POS])
        rst_busy <= 1'b1;

      if (rst_fin)
        run_q <= 1'b0;
      else if (wr_cmd)
        run_q <= bus_wdata[RUN_POS];

      if (rst_fin)
        halted_q <= 1'b1;
      else if (wr_cmd && bus_wdata[RUN_POS])
        halted_q <= 1'b0;
      else if (!run_q && !core_xfer_busy)
        halted_q <= 1'b1;

      if (!run_q || rst_busy)
        hs_seen <= 1'b0;
      else if (core_hs_entered)
        hs_seen <= 1'b1;

      evt_q <= (evt_q & ~clr_mask) | core_evt;
      if (wr_ien) ien_q <= bus_wdata[NUM_EVT-1:0];
    end
  end

  assign core_reset_req = rst_busy;
  assign core_run       = run_q && !rst_busy;
  assign pullup_en      = run_q && !rst_busy && !hs_seen && !core_hs_entered;
  assign irq            = |(evt_q & ien_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CMD) begin
      bus_rdata[RUN_POS] = run_q;
      bus_rdata[RST_POS] = rst_busy;
    end else if (bus_addr == A_STS) begin
      bus_rdata[NUM_EVT-1:0] = evt_q;
      bus_rdata[HALT_POS]    = halted_q;
    end else if (bus_addr == A_IEN) begin
      bus_rdata[NUM_EVT-1:0] = ien_q;
    end
  end

  AST_RST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset_req && !core_reset_done |=> core_reset_req); // R3
  AST_RST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset_req && core_reset_done |=> !core_reset_req && halted_q && !run_q); // R2
  AST_NO_RUN_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset_req |-> !core_run && !pullup_en); // R4
  AST_RUN_NOT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !halted_q); // R5
  AST_HALT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && core_xfer_busy && !halted_q && !core_reset_req |=> !halted_q); // R6
  AST_HS_DROPS_PU: assert property (@(posedge clk) disable iff (!rst_n)
    core_hs_entered |-> !pullup_en); // R7
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    core_evt != '0 |=> (evt_q & $past(core_evt)) == $past(core_evt)); // R8
endmodule

// File: tb/test_usb_cmdstat_regs.sv
module test_usb_cmdstat_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic core_xfer_busy = 1'b0, core_reset_done = 1'b0, core_hs_entered = 1'b0;
  logic [9:0] core_evt = '0;
  logic core_reset_req, core_run, pullup_en, irq;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  usb_cmdstat_regs i_usb_cmdstat_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_xfer_busy(core_xfer_busy),
    .core_reset_done(core_reset_done), .core_evt(core_evt),
    .core_hs_entered(core_hs_entered), .core_reset_req(core_reset_req),
    .core_run(core_run), .pullup_en(pullup_en), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [9:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, v); chk("R1 cmd", v, 32'h0);
    rd(1, v); chk("R1 sts", v, 32'h1000);
    rd(2, v); chk("R1 ien", v, 32'h0);
    chk("R1 outs", {irq, pullup_en, core_run, core_reset_req}, 0);
    // R11 unmapped addresses
    for (int a = 3; a < 16; a++) begin
      rd(a[3:0], v); chk("R11 unmapped", v, 0);
    end
    // R5 run start
    wr(0, 32'h1);
    rd(1, v); chk("R5 halted cleared", v, 32'h0);
    chk("R5 core_run", core_run, 1);
    chk("R7 pullup on", pullup_en, 1);
    // R7 high speed drops pull-up combinationally and stays off
    core_hs_entered = 1'b1; #1 chk("R7 hs drop", pullup_en, 0);
    tick(); core_hs_entered = 1'b0; #1 chk("R7 hs sticky", pullup_en, 0);
    chk("R7 run kept", core_run, 1);
    // R6 stop waits for transaction
    core_xfer_busy = 1'b1;
    wr(0, 32'h0);
    chk("R6 run off", core_run, 0);
    for (int k = 0; k < 4; k++) begin
      rd(1, v); chk("R6 halted waits", v[12], 0); tick();
    end
    core_xfer_busy = 1'b0;
    rd(1, v); chk("R6 not before edge", v[12], 0);
    tick(); rd(1, v); chk("R6 halted set", v[12], 1);
    // R7 pull-up returns after restart
    wr(0, 32'h1); chk("R7 pullup rearmed", pullup_en, 1);
    // R2 R3 R4 controller reset
    wr(0, 32'h3);
    chk("R2 req", core_reset_req, 1);
    rd(0, v); chk("R2 cmd bit", v[1], 1);
    chk("R4 run gated", {core_run, pullup_en}, 0);
    wr(0, 32'h1); rd(0, v); chk("R3 no abort", v[1], 1);
    wr(0, 32'h0); chk("R3 req kept", core_reset_req, 1);
    wr(0, 32'h1);
    repeat (5) tick();
    chk("R2 held", core_reset_req, 1);
    core_reset_done = 1'b1; tick(); core_reset_done = 1'b0;
    chk("R2 req cleared", core_reset_req, 0);
    rd(0, v); chk("R4 cmd cleared", v, 0);
    rd(1, v); chk("R4 halted", v[12], 1);
    // R11 unused command bits
    wr(0, 32'hFFFF_FFFD); rd(0, v); chk("R11 cmd bits", v, 32'h1);
    wr(0, 32'h0); tick();
    // R8 each event bit at its position
    for (int i = 0; i < 10; i++) begin
      core_evt = 10'(1 << i); tick(); core_evt = '0;
      rd(1, v); chk("R8 event bit", v, 32'h1000 | (32'h1 << i));
      wr(1, 32'hFFFF_FFFF); rd(1, v); chk("R9 w1c all, halted kept", v, 32'h1000);
    end
    // R9 partial clear and set-wins
    core_evt = 10'h3FF; tick(); core_evt = '0;
    wr(1, 32'h0); rd(1, v); chk("R9 zero write", v, 32'h13FF);
    wr(1, 32'h0AA); rd(1, v); chk("R9 partial", v, 32'h1355);
    bus_addr = 1; bus_wdata = 32'h3FF; bus_we = 1'b1; core_evt = 10'h004;
    tick(); bus_we = 1'b0; core_evt = '0;
    rd(1, v); chk("R9 set wins", v, 32'h1004);
    wr(1, 32'h3FF);
    // R10 irq sweep over all enable masks for a few status patterns
    foreach (s[j]) s[j] = 1'b0;
    for (int p = 0; p < 3; p++) begin
      s = (p == 0) ? 10'h001 : (p == 1) ? 10'h240 : 10'h000;
      core_evt = s; tick(); core_evt = '0;
      for (int e = 0; e < 1024; e++) begin
        wr(2, 32'(e));
        chk("R10 irq", irq, |(10'(e) & s));
      end
      rd(2, v); chk("R10 ien readback", v, 32'h3FF);
      wr(1, 32'h3FF);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule